// File: doc/BRIEF.md
# Host Byte Port for a Coprocessor Data Register

This block sits between an 8-bit host bus and a 16-bit data register inside a signal-processing coprocessor. A single-cycle host strobe carries a select bit. With the select bit low, the host sees a status byte. With it high, the host moves data through the data register. A width-control input from the core chooses the transfer width. In word mode a 16-bit value crosses as two byte accesses, low byte first, and a byte-phase flag records which half comes next. In byte mode every access moves only the low byte.

A request flag carries the handshake between the two sides. The core sets it when it loads the register, or when it uses its acknowledging read path. The flag clears when the host finishes the last byte of a transfer. The core also has a plain read path that shows the register and changes no flag. If a core strobe and a host data access land in the same cycle, the core strobe wins and the host access is dropped.

Top module: `hdr_port`

## Requirements
- R1: After reset the data register, the byte-phase flag and the request flag are all 0.
- R2: A host read with `host_sel`=0 returns the status byte: request flag at bit 7, width control at bit 3, byte-phase flag at bit 2, other bits 0. Such a read changes no state.
- R3: A host write with `host_sel`=0 is ignored. The data register and both flags keep their values.
- R4: In word mode (`byte_mode`=0), a host data access with the phase flag at 0 moves the low byte (bits 7:0), sets the phase flag to 1 and leaves the request flag unchanged.
- R5: In word mode, a host data access with the phase flag at 1 moves the high byte (bits 15:8), then clears the phase flag and the request flag.
- R6: In byte mode (`byte_mode`=1), each host data access moves only the low byte and clears the request flag. A host write leaves bits 15:8 unchanged, and the phase flag is not changed.
- R7: A core write (`core_wr`) loads `core_wdata` into the data register and sets the request flag to 1.
- R8: The core acknowledging read (`core_take`) sets the request flag and leaves the data register unchanged. `core_rdata` always shows the register and, on its own, changes no flag.
- R9: When `core_wr` or `core_take` is high in the same cycle as a host data access, the host access has no effect on the register or on either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_sel | input | 1 | 0 selects the status byte, 1 selects the data register |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid during the strobe cycle |
| byte_mode | input | 1 | Width control: 0 word transfers, 1 byte transfers |
| core_wr | input | 1 | Core load of the data register |
| core_wdata | input | 16 | Core load value |
| core_take | input | 1 | Core read that also sets the request flag |
| core_rdata | output | 16 | Current data register contents |
| req_flag | output | 1 | Request flag |
| phase_flag | output | 1 | Byte-phase flag |

## Verification
The assertions check, on every cycle, that the request flag rises after any core strobe, that a word-mode data access toggles the phase flag, that the final byte of a transfer clears the request flag, that status accesses leave all state untouched, and that a byte-mode write keeps the high byte. Only the bench scenarios can show the byte order a host sees across a two-access word, the exact layout of the status byte, and the values that come out when a core write collides with a host write.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
   // Classification of one host strobe cycle
   typedef enum logic [1:0] {
      HA_IDLE    = 2'd0,
      HA_STATUS  = 2'd1,
      HA_DATA    = 2'd2,
      HA_BLOCKED = 2'd3
   } host_act_e;
endpackage

// File: rtl/hdr_decode.sv
module hdr_decode
   import hdr_pkg::*;
(
   input  logic      host_rd,
   input  logic      host_wr,
   input  logic      host_sel,
   input  logic      core_wr,
   input  logic      core_take,
   output host_act_e act,
   output logic      data_write
);
   always_comb begin
      if (!(host_rd || host_wr))       act = HA_IDLE;
      else if (!host_sel)              act = HA_STATUS;
      else if (core_wr || core_take)   act = HA_BLOCKED;
      else                             act = HA_DATA;
      data_write = (act == HA_DATA) && host_wr;
   end
endmodule

// File: rtl/hdr_flags.sv
module hdr_flags
   import hdr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  host_act_e act,
   input  logic      byte_mode,
   input  logic      core_wr,
   input  logic      core_take,
   output logic      phase,
   output logic      req
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= 1'b0;
         req   <= 1'b0;
      end else if (core_wr || core_take) begin
         req <= 1'b1;
      end else if (act == HA_DATA) begin
         if (byte_mode) begin
            req <= 1'b0;
         end else if (!phase) begin
            phase <= 1'b1;
         end else begin
            phase <= 1'b0;
            req   <= 1'b0;
         end
      end
   end

   AST_REQ_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      (core_wr || core_take) |=> req); // R7

   AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (act == HA_DATA && !byte_mode) |=> (phase != $past(phase))); // R4

   AST_REQ_CLR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (act == HA_DATA && (byte_mode || phase)) |=> !req); // R5

   AST_BYTE_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (act == HA_DATA && byte_mode) |=> $stable(phase)); // R6
endmodule

// File: rtl/hdr_store.sv
module hdr_store #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   localparam int LANES  = DATA_W / BYTE_W,
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              host_wr_en,
   input  logic [LANE_W-1:0] lane_sel,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [DATA_W-1:0] data_q
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            data_q[g*BYTE_W +: BYTE_W] <= '0;
         else if (core_wr)
            data_q[g*BYTE_W +: BYTE_W] <= core_wdata[g*BYTE_W +: BYTE_W];
         else if (host_wr_en && (lane_sel == LANE_W'(g)))
            data_q[g*BYTE_W +: BYTE_W] <= host_wdata;
      end
   end

   AST_CORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr |=> (data_q == $past(core_wdata))); // R7

   AST_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && lane_sel == '0 && !core_wr)
         |=> $stable(data_q[DATA_W-1:BYTE_W])); // R6
endmodule

// File: rtl/hdr_port.sv
module hdr_port
   import hdr_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int BYTE_W    = 8,
   parameter int STAT_W    = 16,
   parameter int REQ_POS   = 15,
   parameter int WID_POS   = 11,
   parameter int PHASE_POS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic              host_sel,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   input  logic              byte_mode,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              core_take,
   output logic [DATA_W-1:0] core_rdata,
   output logic              req_flag,
   output logic              phase_flag
);
   localparam int LANES     = DATA_W / BYTE_W;
   localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int STAT_BASE = STAT_W - BYTE_W;

   // Elaboration-time parameter checks
   if (DATA_W != 2 * BYTE_W) begin : g_bad_width
      $error("hdr_port: DATA_W must be twice BYTE_W");
   end
   if (REQ_POS < STAT_BASE || WID_POS < STAT_BASE || PHASE_POS < STAT_BASE ||
       REQ_POS >= STAT_W || WID_POS >= STAT_W || PHASE_POS >= STAT_W) begin : g_bad_pos
      $error("hdr_port: status bits must sit in the host-visible byte");
   end
   if (REQ_POS == WID_POS || REQ_POS == PHASE_POS || WID_POS == PHASE_POS) begin : g_bad_dup
      $error("hdr_port: status bit positions must differ");
   end

   host_act_e         act;
   logic              data_write;
   logic              phase;
   logic              req;
   logic [LANE_W-1:0] lane_sel;
   logic [DATA_W-1:0] data_q;
   logic [BYTE_W-1:0] lane_bytes [LANES];
   logic [BYTE_W-1:0] status_hi;

   hdr_decode u_decode (
      .host_rd    (host_rd),
      .host_wr    (host_wr),
      .host_sel   (host_sel),
      .core_wr    (core_wr),
      .core_take  (core_take),
      .act        (act),
      .data_write (data_write)
   );

   hdr_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act),
      .byte_mode (byte_mode),
      .core_wr   (core_wr),
      .core_take (core_take),
      .phase     (phase),
      .req       (req)
   );

   // Byte mode always targets lane 0; word mode follows the phase flag
   assign lane_sel = byte_mode ? '0 : LANE_W'(phase);

   hdr_store #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .core_wr    (core_wr),
      .core_wdata (core_wdata),
      .host_wr_en (data_write),
      .lane_sel   (lane_sel),
      .host_wdata (host_wdata),
      .data_q     (data_q)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
      assign lane_bytes[g] = data_q[g*BYTE_W +: BYTE_W];
   end

   always_comb begin
      status_hi                        = '0;
      status_hi[REQ_POS - STAT_BASE]   = req;
      status_hi[WID_POS - STAT_BASE]   = byte_mode;
      status_hi[PHASE_POS - STAT_BASE] = phase;
   end

   assign host_rdata = host_sel ? lane_bytes[lane_sel] : status_hi;
   assign core_rdata = data_q;
   assign req_flag   = req;
   assign phase_flag = phase;

   AST_STATUS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (act == HA_STATUS && !core_wr && !core_take)
         |=> ($stable(data_q) && $stable(phase) && $stable(req))); // R2 R3

   AST_BLOCKED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (act == HA_BLOCKED && core_take && !core_wr)
         |=> ($stable(data_q) && $stable(phase))); // R9
endmodule

// File: tb/hdr_port_test.sv
module hdr_port_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_sel = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        byte_mode = 1'b0;
   logic        core_wr = 1'b0;
   logic [15:0] core_wdata = '0;
   logic        core_take = 1'b0;
   logic [15:0] core_rdata;
   logic        req_flag;
   logic        phase_flag;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdr_port uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_rd    (host_rd),
      .host_wr    (host_wr),
      .host_sel   (host_sel),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .byte_mode  (byte_mode),
      .core_wr    (core_wr),
      .core_wdata (core_wdata),
      .core_take  (core_take),
      .core_rdata (core_rdata),
      .req_flag   (req_flag),
      .phase_flag (phase_flag)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic core_load(input logic [15:0] v);
      @(negedge clk);
      core_wr = 1'b1; core_wdata = v;
      @(negedge clk);
      core_wr = 1'b0;
   endtask

   task automatic host_read(input logic sel, output logic [7:0] got);
      @(negedge clk);
      host_rd = 1'b1; host_sel = sel;
      #1 got = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic host_write(input logic sel, input logic [7:0] v);
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] b;
      check("R1 data", core_rdata, 16'h0000);
      check("R1 req", 16'(req_flag), 16'h0);
      check("R1 phase", 16'(phase_flag), 16'h0);
      host_read(1'b0, b);
      check("R2 status after reset", 16'(b), 16'h0000);
   endtask

   task automatic t_core_and_status;
      logic [7:0] b;
      core_load(16'hA55A);
      check("R7 data", core_rdata, 16'hA55A);
      check("R7 req", 16'(req_flag), 16'h1);
      host_read(1'b0, b);
      check("R2 status req", 16'(b), 16'h0080);
      check("R2 no change", core_rdata, 16'hA55A);
      host_write(1'b0, 8'hFF);
      check("R3 data", core_rdata, 16'hA55A);
      check("R3 req", 16'(req_flag), 16'h1);
      check("R3 phase", 16'(phase_flag), 16'h0);
   endtask

   task automatic t_word_read;
      logic [7:0] b;
      host_read(1'b1, b);
      check("R4 low byte", 16'(b), 16'h005A);
      check("R4 phase", 16'(phase_flag), 16'h1);
      check("R4 req kept", 16'(req_flag), 16'h1);
      host_read(1'b0, b);
      check("R2 status phase", 16'(b), 16'h0084);
      host_read(1'b1, b);
      check("R5 high byte", 16'(b), 16'h00A5);
      check("R5 phase", 16'(phase_flag), 16'h0);
      check("R5 req", 16'(req_flag), 16'h0);
   endtask

   task automatic t_word_write;
      core_load(16'h0000);
      host_write(1'b1, 8'h34);
      check("R4 write low", core_rdata, 16'h0034);
      check("R4 req kept", 16'(req_flag), 16'h1);
      host_write(1'b1, 8'h12);
      check("R5 write high", core_rdata, 16'h1234);
      check("R5 req", 16'(req_flag), 16'h0);
      check("R5 phase", 16'(phase_flag), 16'h0);
   endtask

   task automatic t_byte_mode;
      logic [7:0] b;
      byte_mode = 1'b1;
      core_load(16'hBEEF);
      host_read(1'b1, b);
      check("R6 read low", 16'(b), 16'h00EF);
      check("R6 req", 16'(req_flag), 16'h0);
      check("R6 phase", 16'(phase_flag), 16'h0);
      host_write(1'b1, 8'h77);
      check("R6 high kept", core_rdata, 16'hBE77);
      host_read(1'b0, b);
      check("R2 status width", 16'(b), 16'h0008);
      // byte mode with phase already set: phase must stay
      byte_mode = 1'b0;
      host_read(1'b1, b);
      byte_mode = 1'b1;
      core_load(16'h00C3);
      host_read(1'b1, b);
      check("R6 low with phase", 16'(b), 16'h00C3);
      check("R6 phase kept", 16'(phase_flag), 16'h1);
      check("R6 req clr", 16'(req_flag), 16'h0);
   endtask

   task automatic t_take;
      @(negedge clk);
      check("R8 plain read", 16'(req_flag), 16'h0);
      check("R8 view", core_rdata, 16'h00C3);
      core_take = 1'b1;
      @(negedge clk);
      core_take = 1'b0;
      check("R8 req set", 16'(req_flag), 16'h1);
      check("R8 data kept", core_rdata, 16'h00C3);
   endtask

   task automatic t_priority;
      byte_mode = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      core_wr = 1'b1; core_wdata = 16'h1111;
      host_wr = 1'b1; host_sel = 1'b1; host_wdata = 8'h22;
      @(negedge clk);
      core_wr = 1'b0; host_wr = 1'b0;
      check("R9 data", core_rdata, 16'h1111);
      check("R9 req", 16'(req_flag), 16'h1);
      check("R9 phase", 16'(phase_flag), 16'h0);
      core_take = 1'b1; host_wr = 1'b1; host_wdata = 8'h33;
      @(negedge clk);
      core_take = 1'b0; host_wr = 1'b0;
      check("R9 take data", core_rdata, 16'h1111);
      check("R9 take phase", 16'(phase_flag), 16'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_core_and_status();
      t_word_read();
      t_word_write();
      t_byte_mode();
      t_take();
      t_priority();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule